// File: doc/BRIEF.md
# Shared-Adder Arithmetic Unit with Sign and Zero Flags

This block is the arithmetic core of a small 8-bit processor. It takes the current 8-bit instruction and two register values, and drives an 8-bit result on the same cycle. The first value is the banked register named by bits 4..3. The second is the register named by bits 2..0. Every operation goes through one adder. Four unary operations share a single path: the second operand is XORed with a copy of bit 4 and bit 3 is added as carry-in. This gives pass, increment, bitwise invert and negate without a decoder of their own. The two-operand add, the register move and the small-immediate load use the same adder, with its inputs steered.

The block also holds a two-bit condition register: a sign flag and a zero flag, both taken from the adder output. The register loads on a clock edge only when an issued instruction has bit 7 clear, which marks the single-cycle arithmetic class. All data pins are plain combinational values. The block has no handshake, because it never stalls and keeps no data between cycles except the flags. The `issue` pin is a plain control qualifier.

Top module: `shared_adder_alu`

## Requirements
- R1: With instr[7:3] = 00000, result equals opb unchanged.
- R2: With instr[7:3] = 00001, result equals opb + 1 modulo 256, so 0xFF gives 0x00.
- R3: With instr[7:3] = 00010, result equals the bitwise inverse of opb.
- R4: With instr[7:3] = 00011, result equals the two's-complement negation of opb modulo 256, so 0x00 gives 0x00 and 0x80 gives 0x80.
- R5: With instr[7:5] = 001, result equals opa.
- R6: With instr[7:5] = 010, result equals instr[2:0] zero-extended to 8 bits.
- R7: With instr[7:5] = 011, result equals opa + opb modulo 256. The carry out of bit 7 is dropped.
- R8: When issue is 1 and instr[7] is 0 at a rising clk edge, the flags load from that cycle's result. flag_neg becomes result bit 7, and flag_zero becomes 1 exactly when all 8 result bits are 0.
- R9: When issue is 0, or when instr[7] is 1, at a rising clk edge, both flags keep their previous values.
- R10: While rst_n is 0, both flags are 0, asynchronously.
- R11: With instr[7] = 1, result equals opb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| issue | input | 1 | Qualifies the current instruction for a flag update |
| instr | input | 8 | Current instruction; bits 7..5 class, 4..3 sub-code, 2..0 immediate |
| opa | input | 8 | Value of the banked first-operand register |
| opb | input | 8 | Value of the second-operand register |
| result | output | 8 | Combinational adder result |
| flag_neg | output | 1 | Registered sign flag |
| flag_zero | output | 1 | Registered zero flag |

## Verification
The hardest cases are flag corners where the carry is dropped. Examples are an add that wraps to exactly zero (0x80 + 0x80), an increment of 0xFF, and negation of 0x80 and of 0x00. Each of these must set the zero or sign flag from the truncated sum. The other hard case is flags that must survive across instructions that do not update them. Directed steps place these corners between branch-class instructions and unissued cycles whose results would flip the flags. A long pseudo-random run then mixes all classes and issue values. A second reset in mid-run shows that the flags clear while the result path keeps working.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int INSTR_W = 8;

  typedef enum logic [2:0] {
    CLS_UNARY = 3'b000,
    CLS_MOVE  = 3'b001,
    CLS_IMM   = 3'b010,
    CLS_SUM   = 3'b011,
    CLS_LONG  = 3'b100
  } op_class_e;

  function automatic op_class_e classify(input logic [INSTR_W-1:0] ins);
    if (ins[7]) return CLS_LONG;
    case (ins[6:5])
      2'b00:   return CLS_UNARY;
      2'b01:   return CLS_MOVE;
      2'b10:   return CLS_IMM;
      default: return CLS_SUM;
    endcase
  endfunction
endpackage

// File: rtl/alu_opsel.sv
module alu_opsel
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DW-1:0]      opa,
  input  logic [DW-1:0]      opb,
  output logic [DW-1:0]      add_a,
  output logic [DW-1:0]      add_b,
  output logic               add_cin,
  output logic               flag_class
);
  localparam int IMM_W = 3;
  localparam int PAD_W = DW - IMM_W;

  op_class_e cls;
  logic [DW-1:0] inv_mask;
  logic [DW-1:0] imm_ext;

  assign cls      = classify(instr);
  assign inv_mask = {DW{instr[4]}};
  assign imm_ext  = {{PAD_W{1'b0}}, instr[IMM_W-1:0]};

  always_comb begin
    add_a   = opb;
    add_b   = '0;
    add_cin = 1'b0;
    unique case (cls)
      CLS_UNARY: begin
        add_a   = opb ^ inv_mask;
        add_cin = instr[3];
      end
      CLS_MOVE: add_a = opa;
      CLS_IMM:  add_a = imm_ext;
      CLS_SUM: begin
        add_a = opa;
        add_b = opb;
      end
      default: add_a = opb;
    endcase
  end

  assign flag_class = ~instr[7];
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum
);
  assign sum = a + b + {{(DW-1){1'b0}}, cin};
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] sum,
  output logic          neg,
  output logic          zero
);
  logic neg_d, zero_d;

  assign neg_d  = sum[DW-1];
  assign zero_d = ~|sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg  <= 1'b0;
      zero <= 1'b0;
    end else if (load) begin
      neg  <= neg_d;
      zero <= zero_d;
    end
  end
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DW-1:0]      opa,
  input  logic [DW-1:0]      opb,
  output logic [DW-1:0]      result,
  output logic               flag_neg,
  output logic               flag_zero
);
  logic [DW-1:0] add_a, add_b, sum;
  logic          add_cin, flag_class;

  alu_opsel #(.DW(DW)) u_opsel (
    .instr      (instr),
    .opa        (opa),
    .opb        (opb),
    .add_a      (add_a),
    .add_b      (add_b),
    .add_cin    (add_cin),
    .flag_class (flag_class)
  );

  alu_adder #(.DW(DW)) u_adder (
    .a   (add_a),
    .b   (add_b),
    .cin (add_cin),
    .sum (sum)
  );

  alu_flagreg #(.DW(DW)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue & flag_class),
    .sum   (sum),
    .neg   (flag_neg),
    .zero  (flag_zero)
  );

  assign result = sum;
endmodule

// File: rtl/shared_adder_alu_chk.sv
module shared_adder_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [7:0]    instr,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [DW-1:0] result,
  input logic          flag_neg,
  input logic          flag_zero
);
  a_r1_test_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[7:3] == 5'b00000) |-> (result == opb));

  a_r2_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[7:3] == 5'b00001) |-> (result == DW'(opb + 1'b1)));

  a_r4_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[7:3] == 5'b00011) |-> (DW'(result + opb) == '0));

  a_r6_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[7:5] == 3'b010) |-> (result == DW'(instr[2:0])));

  a_r7_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[7:5] == 3'b011) |-> (result == DW'(opa + opb)));

  a_r8_flags_load: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !instr[7]) |=>
      (flag_neg == $past(result[DW-1]) && flag_zero == $past(result == '0)));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue || instr[7]) |=> ($stable(flag_neg) && $stable(flag_zero)));

  always_comb begin
    if (!rst_n) a_r10_reset_clear: assert (!flag_neg && !flag_zero);
  end
endmodule

bind shared_adder_alu shared_adder_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .opa(opa),
  .opb(opb), .result(result), .flag_neg(flag_neg), .flag_zero(flag_zero)
);

// File: tb/test_shared_adder_alu.sv
module test_shared_adder_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [7:0] instr = 8'h00;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic [7:0] result;
  logic       flag_neg, flag_zero;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit exp_n = 1'b0;
  bit exp_z = 1'b0;
  string flag_tag = "R10";

  always #5 clk = ~clk;

  shared_adder_alu i_shared_adder_alu (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .opa(opa),
    .opb(opb), .result(result), .flag_neg(flag_neg), .flag_zero(flag_zero)
  );

  function automatic logic [7:0] ref_result(input logic [7:0] i, input logic [7:0] a,
                                            input logic [7:0] b);
    int v;
    if (i[7]) return b;                       // R11
    case (i[6:5])
      2'b00: begin
        case (i[4:3])
          2'b00: v = b;                       // R1
          2'b01: v = b + 1;                   // R2
          2'b10: v = 255 - b;                 // R3
          default: v = (256 - b) % 256;       // R4
        endcase
      end
      2'b01: v = a;                           // R5
      2'b10: v = i & 7;                       // R6
      default: v = (a + b) % 256;             // R7
    endcase
    return v[7:0];
  endfunction

  function automatic string tag_of(input logic [7:0] i);
    if (i[7]) return "R11";
    case (i[6:3])
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0011: return "R4";
      default: ;
    endcase
    case (i[6:5])
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_flags();
    checks++;
    if (flag_neg !== exp_n || flag_zero !== exp_z) begin
      failures++;
      $display("FAIL %s flags actual n=%b z=%b expected n=%b z=%b",
               flag_tag, flag_neg, flag_zero, exp_n, exp_z);
    end
  endtask

  task automatic step(input logic [7:0] i, input logic [7:0] a, input logic [7:0] b,
                      input bit iss);
    logic [7:0] r;
    @(negedge clk);
    check_flags();
    instr = i; opa = a; opb = b; issue = iss;
    #1;
    r = ref_result(i, a, b);
    checks++;
    if (result !== r) begin
      failures++;
      $display("FAIL %s instr=%h result actual %h expected %h", tag_of(i), i, result, r);
    end
    if (iss && !i[7]) begin
      exp_n = r[7]; exp_z = (r == 8'h00); flag_tag = "R8";
    end else begin
      flag_tag = "R9";
    end
  endtask

  task automatic reset_phase();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_n = 1'b0; exp_z = 1'b0; flag_tag = "R10";
    check_flags();
    repeat (2) @(negedge clk);
    check_flags();
    rst_n = 1'b1;
  endtask

  initial begin
    reset_phase();
    step(8'h00, 8'h11, 8'h00, 1'b1);  // R1 zero operand -> Z
    step(8'h08, 8'h00, 8'hFF, 1'b1);  // R2 wrap to zero
    step(8'h10, 8'h00, 8'h00, 1'b1);  // R3 invert -> FF, N
    step(8'h18, 8'h00, 8'h80, 1'b1);  // R4 negate 0x80
    step(8'h18, 8'h00, 8'h00, 1'b1);  // R4 negate zero
    step(8'h18, 8'h00, 8'h01, 1'b1);  // R4 -> FF
    step(8'h20, 8'h7F, 8'h00, 1'b1);  // R5 move
    step(8'h47, 8'hAA, 8'hBB, 1'b1);  // R6 imm 7
    step(8'h40, 8'hAA, 8'hBB, 1'b1);  // R6 imm 0 -> Z
    step(8'h60, 8'h80, 8'h80, 1'b1);  // R7 carry dropped -> Z
    step(8'hC5, 8'h00, 8'h80, 1'b1);  // R11 long class, R9 hold
    step(8'h60, 8'h7F, 8'h01, 1'b0);  // R9 not issued
    step(8'h60, 8'h7F, 8'h01, 1'b1);  // R7 -> 0x80, N
    step(8'hE3, 8'h00, 8'h00, 1'b1);  // R11 zero result, R9 hold
    step(8'h00, 8'h00, 8'h05, 1'b1);  // R1
    reset_phase();                    // R10 mid-run
    for (int k = 0; k < 3000; k++) begin
      step(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    @(negedge clk);
    check_flags();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule